// File: doc/BRIEF.md
# Byte-Serial Timestamp Snapshot Sender

On a one-cycle request, the block takes a snapshot of a free-running time value. The value holds 32 bits of seconds and 20 bits of microseconds. The block then sends that snapshot to a consumer as a short framed message, one byte per clock. The producer and the consumer share a single clock. This block does not keep the time counter, and it does not store the message at the consumer.

A message starts with a single-cycle frame strobe. Eight data bytes follow on the next eight cycles. The four seconds bytes come first, then the four microseconds bytes, and each field is sent least significant byte first. The microseconds field is zero-padded to 32 bits, so the last byte of every message is zero. The block holds the snapshot for the whole message and ignores further requests until the message has finished.

Top module: `ts_byte_sender`

## Requirements
- R1: While `rst` is high and on the cycle after it, `ts_stb` is 0 and `ts_byte` is 0. A reset ends any message that is in progress.
- R2: A `snap_req` sampled at a clock edge while the block is idle latches `sec_in` and `usec_in`. `ts_stb` is then high for exactly the one cycle after that edge, and `ts_byte` is 0 during that cycle.
- R3: On the eight cycles after the strobe cycle, `ts_byte` carries byte indices 0 to 7 in turn. Indices 0 to 3 are seconds bits [7:0], [15:8], [23:16] and [31:24]. Indices 4 to 7 are microseconds bits [7:0], [15:8] and [19:16] (the upper nibble of that byte is zero), followed by 0x00.
- R4: Byte index 6 always has its upper nibble zero, and byte index 7 is always 0x00, whatever the microseconds input is.
- R5: The bytes of a message come from the values latched at the request edge. Changes on `sec_in` and `usec_in` after that edge do not affect them.
- R6: `ts_byte` is 0 on every cycle that is not one of the eight data cycles of a message.
- R7: A `snap_req` sampled during a message produces no strobe and does not alter the bytes still to be sent.
- R8: A request sampled on the edge that ends the last data byte is ignored. A request sampled one edge later is accepted, so every new strobe is preceded by at least one cycle with neither strobe nor data.
- R9: After a reset in the middle of a message, no further bytes of that message appear, and the next request starts a complete new message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the producer and the consumer |
| rst | input | 1 | Synchronous reset, active high |
| sec_in | input | SEC_W (32) | Running seconds value |
| usec_in | input | USEC_W (20) | Running microseconds value |
| snap_req | input | 1 | One-cycle snapshot request |
| ts_stb | output | 1 | Frame strobe, one cycle before the first byte |
| ts_byte | output | BYTE_W (8) | Message byte, zero when no byte is being sent |

## Verification
A corrupted byte index or a bad latch load shows up as a wrong byte on the first data cycle it affects, at most eight cycles after the strobe. A busy flag that clears too early shows up as a second strobe within the same message window, or as a missing idle cycle between two messages. A busy flag that clears too late shows up as a request being dropped one cycle after the last byte. A byte-enable that leaks shows up as a non-zero byte on the strobe cycle or on an idle cycle.

// File: rtl/ts_snd_pkg.sv
package ts_snd_pkg;
  localparam int unsigned DEF_SEC_W  = 32;
  localparam int unsigned DEF_USEC_W = 20;
  localparam int unsigned DEF_BYTE_W = 8;

  // number of lanes of width bw needed to hold bits
  function automatic int unsigned lanes_for(input int unsigned bits, input int unsigned bw);
    return (bits + bw - 1) / bw;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ts_snd_capture.sv
module ts_snd_capture #(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned USEC_W = 20
) (
  input  logic              clk,
  input  logic              load,
  input  logic [SEC_W-1:0]  sec_in,
  input  logic [USEC_W-1:0] usec_in,
  output logic [SEC_W-1:0]  sec_q,
  output logic [USEC_W-1:0] usec_q
);
  // snapshot registers: loaded only on an accepted request
  always_ff @(posedge clk) begin
    if (load) begin
      sec_q  <= sec_in;
      usec_q <= usec_in;
    end
  end
endmodule

// File: rtl/ts_snd_seq.sv
module ts_snd_seq #(
  parameter int unsigned MSG_BYTES = 8,
  localparam int unsigned CNT_W = $clog2(MSG_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  output logic             accept,
  output logic             busy,
  output logic             strobe,
  output logic             byte_en,
  output logic             last_byte,
  output logic [CNT_W-1:0] idx
);
  localparam logic [CNT_W-1:0] END_CNT  = CNT_W'(MSG_BYTES);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MSG_BYTES - 1);

  logic             busy_q;
  logic             stb_q;
  logic [CNT_W-1:0] cnt_q;

  assign accept    = req && !busy_q;
  assign busy      = busy_q;
  assign strobe    = stb_q;
  assign idx       = cnt_q;
  assign byte_en   = busy_q && (cnt_q != END_CNT);
  assign last_byte = busy_q && (cnt_q == LAST_CNT);

  // cnt 0..MSG_BYTES-1 selects the byte driven next, MSG_BYTES is the trailing idle step
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      stb_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      stb_q <= accept;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q == END_CNT) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ts_snd_bytesel.sv
module ts_snd_bytesel #(
  parameter int unsigned SEC_W       = 32,
  parameter int unsigned USEC_W      = 20,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned FIELD_LANES = 4,
  localparam int unsigned MSG_BYTES  = 2 * FIELD_LANES,
  localparam int unsigned FIELD_BITS = FIELD_LANES * BYTE_W,
  localparam int unsigned CNT_W      = $clog2(MSG_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CNT_W-1:0]  idx,
  input  logic [SEC_W-1:0]  sec_q,
  input  logic [USEC_W-1:0] usec_q,
  output logic [BYTE_W-1:0] data
);
  // frame image: seconds field in the low half, zero-padded microseconds above it
  function automatic logic [2*FIELD_BITS-1:0] pack_frame(input logic [SEC_W-1:0] s,
                                                          input logic [USEC_W-1:0] u);
    logic [2*FIELD_BITS-1:0] f;
    f = '0;
    f[SEC_W-1:0] = s;
    f[FIELD_BITS +: USEC_W] = u;
    return f;
  endfunction

  logic [2*FIELD_BITS-1:0] frame;
  logic [BYTE_W-1:0]       lanes [MSG_BYTES];
  logic [BYTE_W-1:0]       sel;
  logic [BYTE_W-1:0]       data_q;

  assign frame = pack_frame(sec_q, usec_q);

  for (genvar g = 0; g < MSG_BYTES; g++) begin : g_lane
    assign lanes[g] = frame[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < MSG_BYTES; i++) begin
      if (idx == CNT_W'(i)) sel = lanes[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     data_q <= '0;
    else if (en) data_q <= sel;
    else         data_q <= '0;
  end

  assign data = data_q;
endmodule

// File: rtl/ts_byte_sender.sv
module ts_byte_sender
  import ts_snd_pkg::*;
#(
  parameter int unsigned SEC_W  = DEF_SEC_W,
  parameter int unsigned USEC_W = DEF_USEC_W,
  parameter int unsigned BYTE_W = DEF_BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEC_W-1:0]  sec_in,
  input  logic [USEC_W-1:0] usec_in,
  input  logic              snap_req,
  output logic              ts_stb,
  output logic [BYTE_W-1:0] ts_byte
);
  localparam int unsigned FIELD_LANES = lanes_for(max_u(SEC_W, USEC_W), BYTE_W);
  localparam int unsigned MSG_BYTES   = 2 * FIELD_LANES;
  localparam int unsigned CNT_W       = $clog2(MSG_BYTES + 1);

  // named internal events, observed by the bound checker
  logic              accept_w;
  logic              busy_w;
  logic              byte_en_w;
  logic              last_w;
  logic [CNT_W-1:0]  idx_w;
  logic [SEC_W-1:0]  sec_lat;
  logic [USEC_W-1:0] usec_lat;

  ts_snd_seq #(.MSG_BYTES(MSG_BYTES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req       (snap_req),
    .accept    (accept_w),
    .busy      (busy_w),
    .strobe    (ts_stb),
    .byte_en   (byte_en_w),
    .last_byte (last_w),
    .idx       (idx_w)
  );

  ts_snd_capture #(.SEC_W(SEC_W), .USEC_W(USEC_W)) u_cap (
    .clk     (clk),
    .load    (accept_w),
    .sec_in  (sec_in),
    .usec_in (usec_in),
    .sec_q   (sec_lat),
    .usec_q  (usec_lat)
  );

  ts_snd_bytesel #(
    .SEC_W(SEC_W), .USEC_W(USEC_W), .BYTE_W(BYTE_W), .FIELD_LANES(FIELD_LANES)
  ) u_sel (
    .clk    (clk),
    .rst    (rst),
    .en     (byte_en_w),
    .idx    (idx_w),
    .sec_q  (sec_lat),
    .usec_q (usec_lat),
    .data   (ts_byte)
  );
endmodule

// File: rtl/ts_byte_sender_chk.sv
module ts_byte_sender_chk #(
  parameter int unsigned SEC_W       = 32,
  parameter int unsigned USEC_W      = 20,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned FIELD_LANES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ts_stb,
  input logic [BYTE_W-1:0] ts_byte,
  input logic              accept_w,
  input logic              busy_w,
  input logic              byte_en_w,
  input logic              last_w,
  input logic [SEC_W-1:0]  sec_lat,
  input logic [USEC_W-1:0] usec_lat
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!ts_stb && ts_byte == '0 && !busy_w));

  a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
    ts_stb |=> !ts_stb);

  a_r2_accept_strobes: assert property (@(posedge clk) disable iff (rst)
    accept_w |=> ts_stb);

  a_r3_first_byte: assert property (@(posedge clk) disable iff (rst)
    ts_stb |=> (ts_byte == sec_lat[BYTE_W-1:0]));

  a_r5_latch_held: assert property (@(posedge clk) disable iff (rst)
    busy_w |=> ($stable(sec_lat) && $stable(usec_lat)));

  a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !byte_en_w |=> (ts_byte == '0));

  a_r7_no_strobe_busy: assert property (@(posedge clk) disable iff (rst)
    busy_w |=> !ts_stb);

  if (USEC_W <= (FIELD_LANES - 1) * BYTE_W) begin : g_pad
    a_r4_last_zero: assert property (@(posedge clk) disable iff (rst)
      last_w |=> (ts_byte == '0));
  end
endmodule

bind ts_byte_sender ts_byte_sender_chk #(
  .SEC_W(SEC_W), .USEC_W(USEC_W), .BYTE_W(BYTE_W), .FIELD_LANES(FIELD_LANES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ts_stb    (ts_stb),
  .ts_byte   (ts_byte),
  .accept_w  (accept_w),
  .busy_w    (busy_w),
  .byte_en_w (byte_en_w),
  .last_w    (last_w),
  .sec_lat   (sec_lat),
  .usec_lat  (usec_lat)
);

// File: tb/ts_byte_sender_tb.sv
module ts_byte_sender_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] sec_in;
  logic [19:0] usec_in;
  logic        snap_req;
  logic        ts_stb;
  logic [7:0]  ts_byte;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ts_byte_sender u_dut (
    .clk(clk), .rst(rst), .sec_in(sec_in), .usec_in(usec_in),
    .snap_req(snap_req), .ts_stb(ts_stb), .ts_byte(ts_byte)
  );

  // expected byte i of a message, by arithmetic on the two fields
  function automatic logic [7:0] exp_byte(input logic [31:0] s, input logic [19:0] u, input int i);
    longint unsigned v;
    v = (i < 4) ? longint'(s) : longint'(u);
    return 8'((v / (64'd1 << (8 * (i % 4)))) % 256);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // call at a negedge with the block idle; ends at the negedge after the idle step
  task automatic send_msg(input logic [31:0] s, input logic [19:0] u, input bit scramble);
    sec_in = s; usec_in = u; snap_req = 1'b1;
    @(negedge clk);
    snap_req = 1'b0;
    if (scramble) begin sec_in = ~s; usec_in = ~u; end
    chk("R2 strobe high", 32'(ts_stb), 32'd1);
    chk("R6 zero on strobe cycle", 32'(ts_byte), 32'd0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i >= 6) chk("R4 padded byte", 32'(ts_byte), 32'(exp_byte(s, u, i)));
      else if (scramble) chk("R5 latched byte", 32'(ts_byte), 32'(exp_byte(s, u, i)));
      else chk("R3 byte order", 32'(ts_byte), 32'(exp_byte(s, u, i)));
      chk("R2 strobe single", 32'(ts_stb), 32'd0);
    end
    @(negedge clk);
    chk("R6 zero after message", 32'(ts_byte), 32'd0);
  endtask

  initial begin
    logic [31:0] lcg;
    rst = 1'b1; snap_req = 1'b0; sec_in = '0; usec_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 strobe in reset", 32'(ts_stb), 32'd0);
    chk("R1 data in reset", 32'(ts_byte), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R6 idle data", 32'(ts_byte), 32'd0);

    send_msg(32'h0, 20'h0, 1'b0);
    send_msg(32'hFFFF_FFFF, 20'hF_FFFF, 1'b0);
    send_msg(32'h0403_0201, 20'h7_0605, 1'b0);
    for (int b = 0; b < 32; b++) send_msg(32'd1 << b, 20'h0, 1'b0);
    for (int b = 0; b < 20; b++) send_msg(32'h0, 20'd1 << b, 1'b0);
    lcg = 32'h1234_5678;
    for (int k = 0; k < 24; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      send_msg(lcg ^ 32'hA5A5_5A5A, 20'(lcg >> 7), 1'b1);
    end

    // R7: request in the middle of a message is ignored
    sec_in = 32'hDEAD_BEEF; usec_in = 20'hC_1234; snap_req = 1'b1;
    @(negedge clk);
    snap_req = 1'b0;
    chk("R7 strobe of first msg", 32'(ts_stb), 32'd1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R7 bytes unchanged", 32'(ts_byte), 32'(exp_byte(32'hDEAD_BEEF, 20'hC_1234, i)));
      chk("R7 no strobe mid message", 32'(ts_stb), 32'd0);
      if (i == 2) begin snap_req = 1'b1; sec_in = 32'h1111_1111; usec_in = 20'h2_2222; end
      if (i == 3) snap_req = 1'b0;
      // R8: request sampled on the edge that ends the last byte
      if (i == 7) begin snap_req = 1'b1; sec_in = 32'h89AB_CDEF; usec_in = 20'h9_8765; end
    end
    @(negedge clk);
    chk("R8 late request ignored", 32'(ts_stb), 32'd0);
    chk("R8 idle gap data", 32'(ts_byte), 32'd0);
    @(negedge clk);
    snap_req = 1'b0;
    chk("R8 next request accepted", 32'(ts_stb), 32'd1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R8 following message byte", 32'(ts_byte), 32'(exp_byte(32'h89AB_CDEF, 20'h9_8765, i)));
    end
    @(negedge clk);

    // R9: reset in the middle of a message aborts it
    sec_in = 32'h5566_7788; usec_in = 20'h3_3344; snap_req = 1'b1;
    @(negedge clk);
    snap_req = 1'b0;
    @(negedge clk);
    chk("R9 byte before abort", 32'(ts_byte), 32'h88);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 strobe after reset", 32'(ts_stb), 32'd0);
    chk("R9 data cleared", 32'(ts_byte), 32'd0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R9 no leftover bytes", 32'(ts_byte), 32'd0);
      chk("R9 no leftover strobe", 32'(ts_stb), 32'd0);
    end
    send_msg(32'hCAFE_F00D, 20'hA_BCDE, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule